// File: doc/BRIEF.md
# Fetch Program Counter

This block holds the fetch address of a pipelined processor front end. On every rising clock edge it picks the next address from four sources. A stall request freezes the address. A jump loads an absolute 32-bit destination. A branch adds a signed 16-bit displacement, taken from the low half of the destination input, to the current address. With no request, the address moves on by one 4-byte word.

Hazard detection, branch resolution and the instruction memory sit outside the block, and the three request lines arrive already decided. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, and while reset is in force the address sits at the boot vector 0xBFBFFFFC.

A running flag is high whenever the address is nonzero. Updates happen only while that flag is high, so once the address reaches zero it stays there until the next reset. A stall indication for the fetch stage copies the stall request combinationally.

Top module: `pc_unit`

## Requirements
- R1: While rst_n is low, pc_o equals 0xBFBFFFFC and running_o is high, regardless of the clock and of the request inputs.
- R2: After rst_n rises, the request inputs have no effect at the first two rising edges. The address first changes at the third rising edge after the release.
- R3: A rising edge with hold_i high leaves pc_o unchanged. If hold_i is high for N consecutive edges, the address is held for exactly N edges.
- R4: A rising edge with jump_i high and hold_i low loads pc_o with dest_i.
- R5: A rising edge with branch_i high and hold_i and jump_i low sets pc_o to pc_o plus dest_i[15:0] sign-extended from bit 15. Bits 31:16 of dest_i are ignored.
- R6: A rising edge with no request advances pc_o by 4, modulo 2^32.
- R7: Priority is fixed: hold_i over jump_i over branch_i.
- R8: running_o is high exactly when pc_o is nonzero.
- R9: While pc_o is zero, no request input changes pc_o.
- R10: fetch_stall_o equals hold_i at all times, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| dest_i | input | 32 | Absolute jump destination; low 16 bits are the branch displacement |
| jump_i | input | 1 | Load dest_i |
| branch_i | input | 1 | Add the sign-extended displacement |
| hold_i | input | 1 | Stall request: keep the current address |
| pc_o | output | 32 | Current fetch address |
| fetch_stall_o | output | 1 | Copy of hold_i for the fetch stage |
| running_o | output | 1 | High while pc_o is nonzero |

## Verification
The assertions check four behaviours on every cycle once the synchronized reset is released: hold freezes the address, a jump loads the destination, a plain step adds four, and a zero address stays at zero. Some behaviours only the bench scenarios can show. These are the asynchronous boot value, the two ignored edges after reset release, signed displacements with junk in the upper destination bits, every priority combination, and the wrap from 0xFFFFFFFC to zero with requests ignored afterwards. The bench also shows that a stall of several cycles holds for exactly that many edges.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Source chosen for the next fetch address
  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_ABS  = 2'd1,
    SRC_REL  = 2'd2,
    SRC_SEQ  = 2'd3
  } pc_src_e;

  localparam int unsigned PC_W_DEF   = 32;
  localparam int unsigned DISP_W_DEF = 16;
  localparam int unsigned STEP_DEF   = 4;

endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/pc_disp_ext.sv
module pc_disp_ext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  disp_i,
  output logic [OUT_W-1:0] disp_o
);

  generate
    if (IN_W < OUT_W) begin : g_extend
      localparam int unsigned PAD = OUT_W - IN_W;
      assign disp_o = {{PAD{disp_i[IN_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_o = disp_i[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pc_src_pick.sv
module pc_src_pick
  import pc_pkg::*;
(
  input  logic    running_i,
  input  logic    hold_i,
  input  logic    jump_i,
  input  logic    branch_i,
  output pc_src_e src_o
);

  always_comb begin
    if (!running_i || hold_i) src_o = SRC_KEEP;
    else if (jump_i)          src_o = SRC_ABS;
    else if (branch_i)        src_o = SRC_REL;
    else                      src_o = SRC_SEQ;
  end

endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = 4
) (
  input  pc_src_e      src_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] dest_i,
  input  logic [W-1:0] disp_i,
  output logic [W-1:0] pc_nxt_o
);

  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] seq_addr;
  logic [W-1:0] rel_addr;

  assign seq_addr = pc_i + STEP_V;
  assign rel_addr = pc_i + disp_i;

  always_comb begin
    unique case (src_i)
      SRC_ABS:  pc_nxt_o = dest_i;
      SRC_REL:  pc_nxt_o = rel_addr;
      SRC_SEQ:  pc_nxt_o = seq_addr;
      default:  pc_nxt_o = pc_i;
    endcase
  end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int unsigned PC_W       = PC_W_DEF,
  parameter int unsigned DISP_W     = DISP_W_DEF,
  parameter int unsigned STEP       = STEP_DEF,
  parameter int unsigned SYNC_STG   = 2,
  parameter logic [PC_W-1:0] BOOT_VEC = 32'hBFBF_FFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] dest_i,
  input  logic            jump_i,
  input  logic            branch_i,
  input  logic            hold_i,
  output logic [PC_W-1:0] pc_o,
  output logic            fetch_stall_o,
  output logic            running_o
);

  logic            rst_sync_n;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] disp_ext;
  logic            pc_en;
  logic            running;
  pc_src_e         src;

  pc_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pc_disp_ext #(.IN_W(DISP_W), .OUT_W(PC_W)) u_ext (
    .disp_i (dest_i[DISP_W-1:0]),
    .disp_o (disp_ext)
  );

  assign running = |pc_q;

  pc_src_pick u_pick (
    .running_i (running),
    .hold_i    (hold_i),
    .jump_i    (jump_i),
    .branch_i  (branch_i),
    .src_o     (src)
  );

  pc_next_calc #(.W(PC_W), .STEP(STEP)) u_calc (
    .src_i    (src),
    .pc_i     (pc_q),
    .dest_i   (dest_i),
    .disp_i   (disp_ext),
    .pc_nxt_o (pc_d)
  );

  assign pc_en = (src != SRC_KEEP);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= BOOT_VEC;
    else if (pc_en)   pc_q <= pc_d;
  end

  assign pc_o          = pc_q;
  assign running_o     = running;
  assign fetch_stall_o = hold_i;

  // R3
  hold_keeps_pc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_i |=> $stable(pc_o));

  // R4
  jump_loads_dest_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hold_i && jump_i && pc_o != '0) |=> (pc_o == $past(dest_i)));

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hold_i && !jump_i && !branch_i && pc_o != '0) |=> (pc_o == $past(pc_o) + PC_W'(STEP)));

  // R9
  zero_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_o == '0) |=> (pc_o == '0));

endmodule

// File: tb/sim_pc_unit.sv
module sim_pc_unit;

  localparam logic [31:0] BOOT = 32'hBFBF_FFFC;

  typedef struct {
    logic [31:0] pc;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] dest_i;
  logic        jump_i, branch_i, hold_i;
  logic [31:0] pc_o;
  logic        fetch_stall_o, running_o;

  int checks = 0;
  int fails  = 0;
  exp_t        sb_q[$];
  logic [31:0] mdl_pc;

  always #5 clk = ~clk;

  pc_unit u0 (
    .clk (clk), .rst_n (rst_n), .dest_i (dest_i), .jump_i (jump_i),
    .branch_i (branch_i), .hold_i (hold_i), .pc_o (pc_o),
    .fetch_stall_o (fetch_stall_o), .running_o (running_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] pc, input logic h,
      input logic j, input logic b, input logic [31:0] d);
    if (pc == 32'h0 || h) return pc;
    if (j)                return d;
    if (b)                return pc + {{16{d[15]}}, d[15:0]};
    return pc + 32'd4;
  endfunction

  // Driver: applies one request per cycle and queues the expected address
  task automatic drive(input logic h, input logic j, input logic b,
      input logic [31:0] d, input bit live, input string req);
    exp_t e;
    @(negedge clk);
    hold_i   <= h;
    jump_i   <= j;
    branch_i <= b;
    dest_i   <= d;
    if (live) mdl_pc = model_next(mdl_pc, h, j, b, d);
    e.pc  = mdl_pc;
    e.req = req;
    sb_q.push_back(e);
    #1;
    chk("R10", {31'b0, fetch_stall_o}, {31'b0, h});
  endtask

  // Monitor: compares after every rising edge while items are queued
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, pc_o, e.pc);
        chk("R8", {31'b0, running_o}, {31'b0, (e.pc != 32'h0)});
      end
    end
  end

  task automatic drain();
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dest_i = '0; jump_i = 0; branch_i = 0; hold_i = 0;
    mdl_pc = BOOT;
    repeat (3) @(negedge clk);
    jump_i <= 1'b1; dest_i <= 32'h1234_5678;
    @(posedge clk); #2;
    // R1: boot value held during reset even with a jump requested
    chk("R1", pc_o, BOOT);
    chk("R1", {31'b0, running_o}, 32'd1);
    @(negedge clk);
    jump_i <= 1'b0;
    rst_n  <= 1'b1;
    // R2: second edge after release still ignores a jump
    drive(0, 1, 0, 32'h0000_4000, 0, "R2");
    // R2: third edge performs the first step
    drive(0, 0, 0, 32'h0, 1, "R2");
    drive(0, 0, 0, 32'h0, 1, "R6");
    // R3: three-cycle hold, then release
    drive(1, 0, 0, 32'h0, 1, "R3");
    drive(1, 0, 0, 32'h0, 1, "R3");
    drive(1, 0, 0, 32'h0, 1, "R3");
    drive(0, 0, 0, 32'h0, 1, "R3");
    // R4: absolute jump
    drive(0, 1, 0, 32'h0000_1000, 1, "R4");
    // R5: positive and negative displacements, upper bits are junk
    drive(0, 0, 1, 32'hDEAD_0010, 1, "R5");
    drive(0, 0, 1, 32'hABCD_FFF0, 1, "R5");
    drive(0, 0, 1, 32'h0000_8000, 1, "R5");
    // R7: priority combinations
    drive(1, 1, 1, 32'h0000_2000, 1, "R7");
    drive(0, 1, 1, 32'h0000_3000, 1, "R7");
    drive(1, 0, 1, 32'h0000_0100, 1, "R7");
    drive(0, 0, 1, 32'h0000_0100, 1, "R7");
    // R6: wrap to zero
    drive(0, 1, 0, 32'hFFFF_FFF8, 1, "R4");
    drive(0, 0, 0, 32'h0, 1, "R6");
    drive(0, 0, 0, 32'h0, 1, "R6");
    // R9: at zero every request is ignored
    drive(0, 1, 0, 32'h0000_0100, 1, "R9");
    drive(0, 0, 1, 32'h0000_0040, 1, "R9");
    drive(0, 0, 0, 32'h0, 1, "R9");
    drain();
    // R1: asynchronous re-entry into reset restores the boot vector
    rst_n <= 1'b0;
    #1;
    chk("R1", pc_o, BOOT);
    chk("R8", {31'b0, running_o}, 32'd1);
    hold_i <= 1'b1;
    #1;
    chk("R10", {31'b0, fetch_stall_o}, 32'd1);
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule